// File: doc/BRIEF.md
# Multicast hash address filter

This block sits on the receive side of an Ethernet MAC. It watches the first six bytes of every incoming frame, which form the destination address, and decides whether the frame should be kept. While the bytes stream in, it runs a serial CRC-32 over them. The top six bits of that CRC select one bit of a 64-bit hash table, and the host loads the table through a simple 16-bit word write port.

A frame is accepted in five cases: promiscuous mode is on, the address is the broadcast address, the address equals the programmed station address, or the address is multicast and either all-multicast mode is on or the selected hash bit is set. The result appears as a one-cycle decision strobe with an accept flag. Frame storage and frame check sequence checking are handled elsewhere.

The byte input follows valid/ready rules. A byte is taken on every clock edge where `rx_valid` and `rx_ready` are both high. The filter never stalls: `rx_ready` is high whenever reset is released. Because of this, an upstream source never has to hold a byte for more than one cycle, and it may leave idle cycles between bytes with `rx_valid` low.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are low and every hash table bit is zero, so a multicast address is rejected when no mode bit is set.
- R2: `rx_ready` is low while `rst_n` is low and high at all other times.
- R3: The hash is computed as follows. The CRC starts at all ones. Each address byte is fed bit 0 first. On each bit step the CRC shifts left, and when (old bit 31 XOR input bit) is 1 it is XORed with 0x04C11DB7. After the sixth byte, bits 31..26 of the uninverted CRC form the 6-bit hash.
- R4: Table word `ht_addr`=w covers hash values 16w..16w+15. Hash value h maps to bit h mod 16 of word h/16, which means bits 5..3 of the hash pick a byte (even bytes in the low half of a word) and bits 2..0 pick the bit in that byte. A write lands on the clock edge where `ht_we` is high.
- R5: `dec_valid` pulses high for exactly one cycle, in the cycle after the sixth address byte is taken. Bytes after the sixth are ignored until the next `rx_sof`.
- R6: A byte taken with `rx_sof` high always starts a new address as byte 0, even when a previous address was only partly received.
- R7: When `mode_promisc` is high at the sixth byte, the frame is accepted.
- R8: The all-ones address is accepted whatever the table and mode bits are.
- R9: An address equal to `sta_addr` is accepted. Address byte k on the wire is compared with `sta_addr[8k+7:8k]`, and a mismatch in any single byte removes the match.
- R10: A multicast address (bit 0 of byte 0 is 1) that is not broadcast is accepted when `mode_allmc` is high or its hash bit is set, and rejected otherwise.
- R11: A unicast address (bit 0 of byte 0 is 0) that does not match the station address is rejected unless promiscuous mode is on. `mode_allmc` has no effect on it.
- R12: Cycles with `rx_valid` low change neither the byte count nor the CRC, so idle gaps between bytes give the same decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte is valid |
| rx_ready | output | 1 | Filter can take a byte (high out of reset) |
| rx_sof | input | 1 | Byte is the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| ht_we | input | 1 | Hash table word write enable |
| ht_addr | input | 2 | Hash table word index |
| ht_wdata | input | 16 | Hash table word data |
| sta_addr | input | 48 | Station address, byte k in bits 8k+7..8k |
| mode_promisc | input | 1 | Accept every frame |
| mode_allmc | input | 1 | Accept every multicast frame |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Decision result, valid with `dec_valid` |

## Verification
The assertions assume that `sta_addr`, `ht_wdata` and the mode bits are stable, known values in any cycle where they are sampled, and that `rx_sof` is only meaningful when `rx_valid` is high. The single-pulse property also assumes that a new frame cannot start within six cycles of the previous sixth byte, which holds for any real Ethernet frame. The stimulus meets these assumptions as follows. It drives every input at the falling edge. It changes mode bits and table words only between frames. It always sends at least six bytes per complete address. Where it aborts a frame with an early `rx_sof`, it does so while fewer than six bytes have been taken.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  localparam int unsigned CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  // Address class flags carried from the tracker to the decision stage.
  typedef struct packed {
    logic is_mc;
    logic is_bc;
    logic is_stn;
  } addr_kind_t;

  // Eight serial CRC steps, least significant input bit first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] b);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[CRC_W-1] ^ b[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/mcf_addr_track.sv
module mcf_addr_track
  import mcf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    sof,
  input  logic [7:0]              data,
  input  logic [8*ADDR_BYTES-1:0] stn,
  output logic                    last_o,
  output logic [HASH_W-1:0]       hash_o,
  output addr_kind_t              kind_o
);

  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam int unsigned SEL_W = CNT_W + 3;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_BYTES);

  logic [CRC_W-1:0] crc_q, crc_in, crc_nx;
  logic [CNT_W-1:0] cnt_q, idx;
  logic [SEL_W-1:0] sel;
  logic             in_addr, use_byte;
  logic             bc_q, bc_nx, st_q, st_nx, mc_q, mc_nx;

  always_comb begin
    in_addr  = (cnt_q != '0) && (cnt_q < FULL_CNT);
    use_byte = take && (sof || in_addr);
    idx      = sof ? '0 : cnt_q;
    sel      = {idx, 3'b000};
    crc_in   = sof ? CRC_SEED : crc_q;
    crc_nx   = crc_step_byte(crc_in, data);
    bc_nx    = (sof ? 1'b1 : bc_q) && (data == 8'hFF);
    st_nx    = (sof ? 1'b1 : st_q) && (data == stn[sel +: 8]);
    mc_nx    = sof ? data[0] : mc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
      cnt_q <= '0;
      bc_q  <= 1'b0;
      st_q  <= 1'b0;
      mc_q  <= 1'b0;
    end else if (use_byte) begin
      crc_q <= crc_nx;
      cnt_q <= idx + CNT_W'(1);
      bc_q  <= bc_nx;
      st_q  <= st_nx;
      mc_q  <= mc_nx;
    end
  end

  assign last_o        = use_byte && (idx == LAST_IDX);
  assign hash_o        = crc_nx[CRC_W-1 -: HASH_W];
  assign kind_o.is_mc  = mc_nx;
  assign kind_o.is_bc  = bc_nx;
  assign kind_o.is_stn = st_nx;

  // R6: a start-of-frame byte always becomes byte 0
  a_r6_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sof) |=> (cnt_q == CNT_W'(1)));

  // R5: count never runs past the address length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R12: idle cycles leave the running state alone
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(cnt_q) && $stable(crc_q)));

endmodule

// File: rtl/mcf_hash_table.sv
module mcf_hash_table #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W*WORDS-1:0]  tbl
);

  localparam int unsigned AW = $clog2(WORDS);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                        word_q <= '0;
      else if (we && waddr == AW'(w))    word_q <= wdata;
    end

    assign tbl[w*WORD_W +: WORD_W] = word_q;

    // R4: a write to this word lands on the next edge
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == AW'(w)) |=> (tbl[w*WORD_W +: WORD_W] == $past(wdata)));
  end

  // R4: without a write the table keeps its contents
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(tbl));

endmodule

// File: rtl/mcf_decide.sv
module mcf_decide
  import mcf_pkg::*;
#(
  parameter int unsigned HASH_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 last,
  input  logic [HASH_W-1:0]    hash,
  input  addr_kind_t           kind,
  input  logic [2**HASH_W-1:0] tbl,
  input  logic                 promisc,
  input  logic                 allmc,
  output logic                 dec_valid,
  output logic                 dec_accept
);

  logic hit, accept;

  always_comb begin
    hit    = tbl[hash];
    accept = promisc || kind.is_bc || kind.is_stn || (kind.is_mc && (allmc || hit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last && accept;
    end
  end

  // R7: promiscuous mode accepts
  a_r7_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (last && promisc) |=> (dec_valid && dec_accept));

  // R8: broadcast accepts
  a_r8_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (last && kind.is_bc) |=> dec_accept);

  // R11: foreign unicast rejected
  a_r11_unicast_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !kind.is_mc && !kind.is_stn && !promisc) |=> !dec_accept);

  // R5: accept only with the strobe
  a_r5_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
  import mcf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned TBL_WORDS  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  output logic                         rx_ready,
  input  logic                         rx_sof,
  input  logic [7:0]                   rx_data,
  input  logic                         ht_we,
  input  logic [$clog2(TBL_WORDS)-1:0] ht_addr,
  input  logic [WORD_W-1:0]            ht_wdata,
  input  logic [8*ADDR_BYTES-1:0]      sta_addr,
  input  logic                         mode_promisc,
  input  logic                         mode_allmc,
  output logic                         dec_valid,
  output logic                         dec_accept
);

  localparam int unsigned TBL_BITS = WORD_W * TBL_WORDS;
  localparam int unsigned HASH_W   = $clog2(TBL_BITS);

  logic                 take, last;
  logic [HASH_W-1:0]    hash;
  addr_kind_t           kind;
  logic [TBL_BITS-1:0]  tbl;

  assign rx_ready = rst_n;
  assign take     = rx_valid && rx_ready;

  mcf_addr_track #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(rx_sof), .data(rx_data),
    .stn(sta_addr), .last_o(last), .hash_o(hash), .kind_o(kind)
  );

  mcf_hash_table #(.WORD_W(WORD_W), .WORDS(TBL_WORDS)) u_table (
    .clk(clk), .rst_n(rst_n), .we(ht_we), .waddr(ht_addr), .wdata(ht_wdata),
    .tbl(tbl)
  );

  mcf_decide #(.HASH_W(HASH_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .last(last), .hash(hash), .kind(kind), .tbl(tbl),
    .promisc(mode_promisc), .allmc(mode_allmc),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // R2: ready follows reset
  a_r2_ready: assert property (@(posedge clk) rx_ready == rst_n);

  if (ADDR_BYTES > 1) begin : g_pulse
    // R5: decision strobe lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);
  end

endmodule

// File: tb/sim_mcast_addr_filter.sv
`timescale 1ns/1ps
module sim_mcast_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        ht_we = 1'b0;
  logic [1:0]  ht_addr = '0;
  logic [15:0] ht_wdata = '0;
  logic [47:0] sta_addr = 48'hBEEF_CAFE_1002;
  logic        mode_promisc = 1'b0, mode_allmc = 1'b0;
  logic        dec_valid, dec_accept;

  int n_chk = 0, n_fail = 0;
  logic [63:0] sh_tbl = '0;

  always #10 clk = ~clk;

  mcast_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sof(rx_sof), .rx_data(rx_data), .ht_we(ht_we), .ht_addr(ht_addr),
    .ht_wdata(ht_wdata), .sta_addr(sta_addr), .mode_promisc(mode_promisc),
    .mode_allmc(mode_allmc), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reflected-register model of the hash (right shift, reversed polynomial).
  function automatic logic [5:0] model_hash(input logic [47:0] da);
    logic [31:0] r;
    logic fb;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      fb = r[0] ^ da[k];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic model_accept(input logic [47:0] da);
    return mode_promisc || (da == 48'hFFFF_FFFF_FFFF) || (da == sta_addr) ||
           (da[0] && (mode_allmc || sh_tbl[model_hash(da)]));
  endfunction

  task automatic wr_word(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); ht_we = 1'b1; ht_addr = a; ht_wdata = d;
    @(negedge clk); ht_we = 1'b0;
    sh_tbl[a*16 +: 16] = d;
  endtask

  task automatic load_table(input logic [63:0] t);
    for (int w = 0; w < 4; w++) wr_word(2'(w), t[w*16 +: 16]);
  endtask

  task automatic send_bytes(input logic [47:0] da, input int n, input int gap,
                            input logic first_sof);
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap && k > 0; g++) begin
        @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
        chk(!dec_valid, "R12 no strobe in gap", 64'(dec_valid), 0);
      end
      @(negedge clk);
      if (k > 0) chk(!dec_valid, "R5 no early strobe", 64'(dec_valid), 0);
      rx_valid = 1'b1; rx_sof = first_sof && (k == 0); rx_data = da[8*k +: 8];
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] da, input int gap, input string tag);
    logic e;
    e = model_accept(da);
    send_bytes(da, 6, gap, 1'b1);
    chk(dec_valid === 1'b1, {tag, " strobe"}, 64'(dec_valid), 1);
    chk(dec_accept === e, {tag, " accept"}, 64'(dec_accept), 64'(e));
    @(negedge clk);
    chk(dec_valid === 1'b0, "R5 single pulse", 64'(dec_valid), 0);
  endtask

  localparam logic [47:0] MC1 = 48'h0100_5E00_0001;
  localparam logic [47:0] MC2 = 48'h9A78_5634_1203;
  localparam logic [47:0] UC1 = 48'h5544_3322_1100;

  task automatic t_reset;
    chk(rx_ready === 1'b0, "R2 ready low in reset", 64'(rx_ready), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_valid === 1'b0 && dec_accept === 1'b0, "R1 outputs idle",
        {62'd0, dec_valid, dec_accept}, 0);
    chk(rx_ready === 1'b1, "R2 ready high", 64'(rx_ready), 1);
    run_frame(MC1, 0, "R1 R10 empty table rejects multicast");
  endtask

  task automatic t_hash;
    logic [5:0] h1, h2;
    h1 = model_hash(MC1);
    h2 = model_hash(MC2);
    load_table(~(64'd1 << h1));
    if (h1 != h2) run_frame(MC2, 0, "R3 R4 other bit accepts");
    run_frame(MC1, 0, "R3 R4 own bit clear rejects");
    load_table(64'd1 << h1);
    run_frame(MC1, 0, "R3 R4 own bit set accepts");
    chk(model_accept(MC1) == 1'b1, "R3 model sanity", 0, 1);
    load_table(64'd1 << h2);
    run_frame(MC2, 0, "R10 second multicast accepts");
    load_table('0);
  endtask

  task automatic t_allmc;
    mode_allmc = 1'b1;
    run_frame(MC2, 0, "R10 all-multicast accepts");
    run_frame(UC1, 0, "R11 all-multicast ignores unicast");
    mode_allmc = 1'b0;
    run_frame(UC1, 0, "R11 foreign unicast rejected");
  endtask

  task automatic t_promisc;
    mode_promisc = 1'b1;
    run_frame(UC1, 0, "R7 promiscuous unicast");
    run_frame(MC1, 0, "R7 promiscuous multicast");
    mode_promisc = 1'b0;
  endtask

  task automatic t_bcast;
    run_frame(48'hFFFF_FFFF_FFFF, 0, "R8 broadcast accepted");
  endtask

  task automatic t_station;
    run_frame(sta_addr, 0, "R9 station match");
    run_frame(sta_addr ^ 48'h0100_0000_0000, 0, "R9 last byte differs");
    run_frame(sta_addr ^ 48'h0000_0000_0100, 0, "R9 second byte differs");
  endtask

  task automatic t_gaps;
    run_frame(sta_addr, 2, "R12 gapped station frame");
    load_table(64'd1 << model_hash(MC1));
    run_frame(MC1, 3, "R12 gapped multicast");
    load_table('0);
  endtask

  task automatic t_restart;
    send_bytes(UC1, 3, 0, 1'b1);
    chk(!dec_valid, "R6 partial gives no strobe", 64'(dec_valid), 0);
    run_frame(sta_addr, 0, "R6 restart after partial");
  endtask

  task automatic t_trailing;
    run_frame(UC1, 0, "R5 frame before trailing bytes");
    send_bytes(sta_addr, 6, 0, 1'b0);
    chk(!dec_valid, "R5 trailing bytes ignored", 64'(dec_valid), 0);
    @(negedge clk);
    chk(!dec_valid, "R5 trailing bytes ignored late", 64'(dec_valid), 0);
  endtask

  initial begin
    t_reset();
    t_hash();
    t_allmc();
    t_promisc();
    t_bcast();
    t_station();
    t_gaps();
    t_restart();
    t_trailing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule